// File: doc/BRIEF.md
# Caption data slice line selector

This block qualifies video lines for a closed-caption data slicer. On every line start it compares the current line number with two candidate lines. One is a fixed caption line, line 21. The other is a line programmed through a five-bit register field. It raises two strobes from these comparisons. The first, "slice this line", tells the downstream slicer to capture data. The second, "generate slice level", tells the reference-level circuit to learn its threshold from the clock run-in of this line.

Data slicing follows a two-bit mode and runs in both fields. Slice-level generation runs only in the one field chosen by a field-select bit. The configuration (mode, programmable line, field-select bit) and the field identity are captured at each field start. Writes during a field are therefore held off until the next field. When both lines are in use, a programmable value above 29 is clamped to 29. Line counting, the clamp, the analog reference generator and the comparator are outside this block.

Top module: `caption_line_sel`

## Requirements
- R1: After reset both strobes are low. The captured configuration is mode 00, programmable line 0, level field 0 and field 0, so line 21 of the first field is qualified for slicing and for level generation.
- R2: In mode 00 (`cfg_mode` = 2'b00), only line 21 is sliced. This holds in both fields.
- R3: In mode 01, only the programmable line is sliced. Its line number equals the captured 5-bit value, and any value from 0 to 31 is used as written.
- R4: In modes 10 and 11, both line 21 and the programmable line are sliced in both fields.
- R5: `level_en` can be high only on lines of the field whose captured `field_id` (0 = first field, 1 = second field) equals the captured `cfg_level_field`.
- R6: Inside that field, the level line depends on the mode. Modes 00 and 11 use line 21. Modes 01 and 10 use the programmable line.
- R7: In modes 10 and 11, a programmable value of 30 or 31 is captured as 29. In mode 01 no clamping is applied.
- R8: `cfg_mode`, `cfg_line`, `cfg_level_field` and `field_id` are captured only on a cycle with `field_start` high. Changes on these inputs at any other time have no effect until the next field start. If `line_start` is high in the same cycle as `field_start`, the line decision already uses the newly captured values.
- R9: The strobes change only in the cycle after a `line_start` or `field_start` pulse. A qualifying `line_start` raises them from the next cycle until the next `line_start`. A `field_start` without `line_start` drops them.
- R10: `level_en` is never high while `slice_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle pulse at the start of a field; captures configuration |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| field_id | input | 1 | Field indicator: 0 first field, 1 second field |
| line_num | input | LINE_W | Number of the line starting with `line_start` |
| cfg_mode | input | 2 | Line mode: 00 line 21, 01 programmable, 10/11 both |
| cfg_line | input | 5 | Programmable line number |
| cfg_level_field | input | 1 | Field in which slice-level generation is allowed |
| slice_en | output | 1 | High for the whole line period of a line to be sliced |
| level_en | output | 1 | High for the whole line period of a line that drives slice-level generation |

## Verification
The hardest case to reach from the ports is a write made during a field. Such a write must stay invisible while lines keep coming, and must then take hold exactly at the following field start, even when that start coincides with a line start. The stimulus changes every configuration input on every line of every field, so anything that leaks through is visible. Some fields open with `field_start` and `line_start` together, and others open with `field_start` alone. The random programmable values are weighted towards 29 to 31 and towards 21, so the clamp and the case where both candidates fall on the same line are exercised often.

// File: rtl/caption_line_sel_pkg.sv
// Shared types and constants for the caption data slice line selector.
package caption_line_sel_pkg;

    localparam int PROG_W = 5;
    localparam logic [PROG_W-1:0] PROG_MAX_BOTH = 5'd29;

    typedef enum logic [1:0] {
        MODE_FIXED   = 2'b00,
        MODE_PROG    = 2'b01,
        MODE_BOTH_PL = 2'b10,
        MODE_BOTH_FL = 2'b11
    } line_mode_e;

    typedef struct packed {
        line_mode_e        mode;
        logic [PROG_W-1:0] line;
        logic              lvl_field;
        logic              field;
    } sel_cfg_t;

    // Clamp a programmable value to the legal maximum of the given mode.
    function automatic logic [PROG_W-1:0] clamp_line(line_mode_e m, logic [PROG_W-1:0] v);
        if ((m == MODE_BOTH_PL || m == MODE_BOTH_FL) && v > PROG_MAX_BOTH)
            return PROG_MAX_BOTH;
        return v;
    endfunction

endpackage

// File: rtl/cls_cfg_latch.sv
// Configuration capture: holds mode, programmable line, level field and field
// identity captured at each field start. Assumes field_start is a single-cycle pulse.
// The effective output shows the incoming values during the capture cycle itself.
module cls_cfg_latch
    import caption_line_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              field_id,
    input  logic [1:0]        cfg_mode,
    input  logic [PROG_W-1:0] cfg_line,
    input  logic              cfg_level_field,
    output sel_cfg_t          cfg_eff,
    output sel_cfg_t          cfg_held
);
    sel_cfg_t cfg_new;

    // Build the clamped candidate configuration from the inputs.
    always_comb begin
        cfg_new.mode      = line_mode_e'(cfg_mode);
        cfg_new.line      = clamp_line(line_mode_e'(cfg_mode), cfg_line);
        cfg_new.lvl_field = cfg_level_field;
        cfg_new.field     = field_id;
    end

    // Capture the candidate configuration on a field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_held <= '{mode: MODE_FIXED, line: '0, lvl_field: 1'b0, field: 1'b0};
        end else if (field_start) begin
            cfg_held <= cfg_new;
        end
    end

    // Effective configuration for a line starting in the capture cycle.
    always_comb begin
        cfg_eff = field_start ? cfg_new : cfg_held;
    end

endmodule

// File: rtl/cls_line_match.sv
// Line qualification: compares the line number with the fixed caption line and
// the programmable line, and derives the slice and level decisions for the mode.
// Purely combinational; assumes LINE_W is wide enough to hold FIXED_LINE.
module cls_line_match
    import caption_line_sel_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int FIXED_LINE = 21
) (
    input  sel_cfg_t          cfg,
    input  logic [LINE_W-1:0] line_num,
    output logic              want_slice,
    output logic              want_level
);
    localparam int NCAND = 2;   // index 0: fixed line, index 1: programmable line
    localparam logic [LINE_W-1:0] FIXED_L = LINE_W'(FIXED_LINE);

    logic [LINE_W-1:0] cand      [NCAND];
    logic [NCAND-1:0]  hit;
    logic [NCAND-1:0]  slice_use;
    logic [NCAND-1:0]  level_use;
    logic              field_ok;

    // Candidate line numbers.
    always_comb begin
        cand[0] = FIXED_L;
        cand[1] = LINE_W'(cfg.line);
    end

    // One comparator per candidate line.
    for (genvar i = 0; i < NCAND; i++) begin : g_cmp
        assign hit[i] = (line_num == cand[i]);
    end

    // Mode decode: which candidates slice and which feed the level.
    always_comb begin
        slice_use[0] = (cfg.mode != MODE_PROG);
        slice_use[1] = (cfg.mode != MODE_FIXED);
        level_use[0] = (cfg.mode == MODE_FIXED) || (cfg.mode == MODE_BOTH_FL);
        level_use[1] = (cfg.mode == MODE_PROG)  || (cfg.mode == MODE_BOTH_PL);
        field_ok     = (cfg.field == cfg.lvl_field);
    end

    // Final decisions.
    always_comb begin
        want_slice = |(hit & slice_use);
        want_level = field_ok && |(hit & level_use);
    end

endmodule

// File: rtl/cls_strobe_reg.sv
// Strobe register: loads the decisions on each line start, holds them for the
// line period and clears them on a field start that has no line start.
module cls_strobe_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic field_start,
    input  logic want_slice,
    input  logic want_level,
    output logic slice_en,
    output logic level_en
);
    // Update the strobes at line and field boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_en <= 1'b0;
            level_en <= 1'b0;
        end else if (line_start) begin
            slice_en <= want_slice;
            level_en <= want_level;
        end else if (field_start) begin
            slice_en <= 1'b0;
            level_en <= 1'b0;
        end
    end

endmodule

// File: rtl/caption_line_sel.sv
// Top of the caption data slice line selector. Decides per line whether data is
// sliced and whether the slice level is generated. Assumes line_num is valid in
// the cycle of line_start and that field_start and line_start are one-cycle pulses.
module caption_line_sel
    import caption_line_sel_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int FIXED_LINE = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_start,
    input  logic              field_id,
    input  logic [LINE_W-1:0] line_num,
    input  logic [1:0]        cfg_mode,
    input  logic [4:0]        cfg_line,
    input  logic              cfg_level_field,
    output logic              slice_en,
    output logic              level_en
);
    sel_cfg_t cfg_eff;
    sel_cfg_t cfg_held;
    logic     want_slice;
    logic     want_level;

    cls_cfg_latch u_cfg (
        .clk             (clk),
        .rst_n           (rst_n),
        .field_start     (field_start),
        .field_id        (field_id),
        .cfg_mode        (cfg_mode),
        .cfg_line        (cfg_line),
        .cfg_level_field (cfg_level_field),
        .cfg_eff         (cfg_eff),
        .cfg_held        (cfg_held)
    );

    cls_line_match #(
        .LINE_W     (LINE_W),
        .FIXED_LINE (FIXED_LINE)
    ) u_match (
        .cfg        (cfg_eff),
        .line_num   (line_num),
        .want_slice (want_slice),
        .want_level (want_level)
    );

    cls_strobe_reg u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .field_start (field_start),
        .want_slice  (want_slice),
        .want_level  (want_level),
        .slice_en    (slice_en),
        .level_en    (level_en)
    );

endmodule

// File: rtl/caption_line_sel_chk.sv
// Property checker for the caption data slice line selector, bound to the top.
module caption_line_sel_chk
    import caption_line_sel_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     field_start,
    input logic     line_start,
    input logic     slice_en,
    input logic     level_en,
    input sel_cfg_t cfg_held
);
    // R10: a level line is always a sliced line
    a_r10_level_in_slice: assert property (@(posedge clk) disable iff (!rst_n)
        level_en |-> slice_en);

    // R9: no boundary pulse means the strobes hold
    a_r9_hold_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !field_start) |=> ($stable(slice_en) && $stable(level_en)));

    // R9: a field start alone drops both strobes
    a_r9_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && !line_start) |=> (!slice_en && !level_en));

    // R8: the captured configuration moves only on a field start
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(cfg_held));

    // R7: in the two-line modes the held line never exceeds 29
    a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_held.mode == MODE_BOTH_PL || cfg_held.mode == MODE_BOTH_FL) |-> (cfg_held.line <= PROG_MAX_BOTH));

endmodule

bind caption_line_sel caption_line_sel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .line_start  (line_start),
    .slice_en    (slice_en),
    .level_en    (level_en),
    .cfg_held    (cfg_held)
);

// File: tb/tb_caption_line_sel.sv
// Self-checking bench: random fields with configuration churn, plus directed cases.
module tb_caption_line_sel;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              field_start = 1'b0;
    logic              line_start = 1'b0;
    logic              field_id = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic [1:0]        cfg_mode = 2'b00;
    logic [4:0]        cfg_line = 5'd0;
    logic              cfg_level_field = 1'b0;
    logic              slice_en;
    logic              level_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference state captured at field start
    logic [1:0] m_mode  = 2'b00;
    logic [4:0] m_line  = 5'd0;
    logic       m_lf    = 1'b0;
    logic       m_fid   = 1'b0;
    logic       e_slice = 1'b0;
    logic       e_level = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    caption_line_sel #(.LINE_W(LINE_W), .FIXED_LINE(21)) dut (
        .clk (clk), .rst_n (rst_n), .field_start (field_start), .line_start (line_start),
        .field_id (field_id), .line_num (line_num), .cfg_mode (cfg_mode), .cfg_line (cfg_line),
        .cfg_level_field (cfg_level_field), .slice_en (slice_en), .level_en (level_en)
    );

    function automatic logic [4:0] ref_clamp(logic [1:0] m, logic [4:0] v);
        return (m[1] && v > 5'd29) ? 5'd29 : v;
    endfunction

    function automatic logic ref_slice(logic [1:0] m, logic [4:0] pl, int ln);
        logic f = (ln == 21);
        logic p = (ln == int'(pl));
        case (m)
            2'b00:   return f;
            2'b01:   return p;
            default: return f | p;
        endcase
    endfunction

    function automatic logic ref_level(logic [1:0] m, logic [4:0] pl, logic lf, logic fid, int ln);
        if (lf != fid) return 1'b0;
        case (m)
            2'b00, 2'b11: return (ln == 21);
            default:      return (ln == int'(pl));
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update reference at posedge, sample 1 time unit later.
    task automatic step(input bit fs, input bit ls, input int ln, input bit fid,
                        input logic [1:0] m, input logic [4:0] pl, input bit lf);
        string st, lt;
        @(negedge clk);
        field_start = fs; line_start = ls; line_num = LINE_W'(ln);
        field_id = fid; cfg_mode = m; cfg_line = pl; cfg_level_field = lf;
        @(posedge clk);
        if (fs) begin
            m_mode = m; m_line = ref_clamp(m, pl); m_lf = lf; m_fid = fid;
        end
        if (ls) begin
            e_slice = ref_slice(m_mode, m_line, ln);
            e_level = ref_level(m_mode, m_line, m_lf, m_fid, ln);
        end else if (fs) begin
            e_slice = 1'b0; e_level = 1'b0;
        end
        #1;
        if (!ls && !fs) begin st = "R9"; lt = "R9"; end
        else begin
            case (m_mode)
                2'b00:   st = "R2";
                2'b01:   st = "R3";
                default: st = (m_line == 5'd29) ? "R7" : "R4";
            endcase
            lt = (m_lf == m_fid) ? "R6" : "R5";
        end
        if (fs) begin st = {st, " R8"}; lt = {lt, " R8"}; end
        check({st, " slice_en"}, slice_en, e_slice);
        check({lt, " level_en"}, level_en, e_level);
        if (level_en && !slice_en) check("R10 level without slice", 1'b1, 1'b0);
        field_start = 1'b0; line_start = 1'b0;
    endtask

    function automatic logic [4:0] rand_line();
        int r = $urandom_range(0, 9);
        if (r < 3) return 5'(29 + $urandom_range(0, 2));
        if (r < 5) return 5'd21;
        return 5'($urandom_range(0, 31));
    endfunction

    // Run one field; configuration inputs are scrambled on every later line (R8).
    task automatic run_field(input bit fid, input logic [1:0] m, input logic [4:0] pl,
                             input bit lf, input bit coincide, input int nlines);
        if (coincide) step(1, 1, 0, fid, m, pl, lf);
        else step(1, 0, 0, fid, m, pl, lf);
        for (int ln = coincide ? 1 : 0; ln < nlines; ln++) begin
            step(0, 1, ln, 1'($urandom), 2'($urandom), 5'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) step(0, 0, ln, 1'($urandom), 2'($urandom), 5'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0C));
        repeat (3) @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 slice_en at reset", slice_en, 1'b0);
        check("R1 level_en at reset", level_en, 1'b0);
        // R1: reset configuration qualifies line 21 of field 0 with no field start
        for (int ln = 19; ln < 24; ln++) step(0, 1, ln, 0, 2'b00, 5'd0, 0);

        // R7: directed clamp, mode 10 value 31 -> line 29 sliced and leveled, 31 not
        run_field(0, 2'b10, 5'd31, 0, 1'b1, 33);
        // R3: mode 01 value 31 used unclamped
        run_field(1, 2'b01, 5'd31, 1, 1'b0, 33);
        // R5: level field mismatch
        run_field(1, 2'b11, 5'd5, 0, 1'b1, 25);
        // R6: both candidates on the same line
        run_field(0, 2'b10, 5'd21, 0, 1'b0, 24);

        for (int f = 0; f < 120; f++)
            run_field(1'(f), 2'($urandom), rand_line(), 1'($urandom), 1'($urandom),
                      $urandom_range(22, 34));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule